// File: doc/BRIEF.md
# Page Access Rights Checker

This block judges one linear-address translation while its page-table walk is in progress. A walk begins with a single-cycle start strobe. The strobe captures the access type (read, write or instruction fetch), the privilege level (user or supervisor), the paging mode and the no-execute enable, and it resets the accumulated rights. The walker then presents the table entries one per accepted cycle, from the root level down to the leaf, and marks the final entry as last. The block folds each entry into running rights: writable and user must hold at every level, and execute-disable counts if any level sets it.

The walk ends early at the first entry that does not describe a valid translation. Otherwise it ends on the entry marked last. One cycle after the deciding entry, the block pulses a result strobe. A fault strobe comes with it when the access is refused. The fault carries exception vector 14 and an error code that says why the access failed and what kind of access it was. Fetching the entries, computing addresses and caching translations are left to the surrounding walker.

Top module: `page_rights_check`

## Requirements
- R1: After reset, resultValid and faultValid are low, and faultVector and faultCode are zero.
- R2: A walkStart cycle captures the access attributes and resets the rights to writable, user and not execute-disabled. accKind encodes 0 = read, 1 = write and 2 = fetch. pageMode encodes 0 = 32-bit, 1 = PAE and 2 = 4-level. Entries offered in the start cycle, or while no walk is in progress, are ignored.
- R3: Entry bit 0 is present, bit 1 is writable, bit 2 is user and bit 63 is execute-disable. An accepted entry with bit 0 clear ends the walk. One cycle later a fault is reported with error-code bit 0 = 0.
- R4: In pageMode 1 or 2, an entry with any of bits 62..52 set is invalid. The walk ends and one cycle later a fault is reported with error-code bits 0 and 3 set. In pageMode 0 these bits are ignored. A non-present entry reports bit 0 = 0 and bit 3 = 0 even if it also has reserved bits set.
- R5: One cycle after the entry marked last is accepted, resultValid pulses for exactly one cycle. faultValid pulses with it only when the access is refused. faultVector is 14 during a fault and 0 otherwise.
- R6: On a valid translation, supervisor reads and writes are always permitted. A supervisor fetch is refused only by the execute-disable rule of R9.
- R7: A user read is permitted only if the user bit is 1 in every entry of the walk.
- R8: A user write is permitted only if both the user bit and the writable bit are 1 in every entry.
- R9: Execute-disable checking is active when the no-execute enable is 1 and pageMode is 1 or 2. While it is active, a fetch is refused if any entry has bit 63 set. While it is inactive, bit 63 is ignored. A user fetch also needs the user bit in every entry.
- R10: In a fault, error-code bit 1 = the access was a write, bit 2 = user mode, and bit 4 = a fetch made while execute-disable checking was active. All bits above 4 are zero. faultCode is zero whenever faultValid is low.
- R11: After a walk ends early, further entries are ignored until the next walkStart, so each walk gives at most one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkStart | input | 1 | Begins a walk, captures the attributes and resets the rights |
| accKind | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| userMode | input | 1 | 1 = user-mode access, 0 = supervisor |
| pageMode | input | 2 | 0 = 32-bit, 1 = PAE, 2 = 4-level |
| nxEnable | input | 1 | No-execute enable control |
| entryValid | input | 1 | entryData carries a table entry this cycle |
| entryLast | input | 1 | The entry is the leaf of the walk |
| entryData | input | ENTRY_W | Table entry contents |
| resultValid | output | 1 | One-cycle pulse when a walk is decided |
| faultValid | output | 1 | One-cycle pulse when the access is refused |
| faultVector | output | VEC_W | Exception vector, 14 during a fault |
| faultCode | output | ERR_W | Error code during a fault |

## Verification
Every result is due exactly one clock after the rising edge that accepts the deciding entry. That entry is either the first invalid one or the one marked last. The bench drives each entry at a falling edge. At each following falling edge it notes whether a result pulse is present and records the index of the entry that pulse follows, so early stops are checked at the exact entry. Sampling goes on for two cycles past the final entry, which catches a second or stray pulse from entries that should have been ignored.

// File: rtl/page_rights_pkg.sv
package page_rights_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_e;

  typedef enum logic [1:0] {
    PM_LEGACY = 2'd0,
    PM_PAE    = 2'd1,
    PM_LONG   = 2'd2
  } pageMode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic clearAcc;
    logic takeEntry;
    logic finish;
  } walkStrobe_t;

  localparam int PRESENT_BIT = 0;
  localparam int WRITE_BIT   = 1;
  localparam int USER_BIT    = 2;

  localparam int ERR_P     = 0;
  localparam int ERR_WR    = 1;
  localparam int ERR_US    = 2;
  localparam int ERR_RSVD  = 3;
  localparam int ERR_FETCH = 4;
  localparam int ERR_USED  = 5;

  localparam int PF_VECTOR = 14;

endpackage

// File: rtl/page_rights_ctrl.sv
module page_rights_ctrl
  import page_rights_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        walkStart,
  input  logic        entryValid,
  input  logic        entryLast,
  input  logic        entryBad,
  output walkStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_WALK} walkState_e;
  walkState_e state, stateNext;

  always_comb begin
    strobe          = '0;
    stateNext       = state;
    strobe.clearAcc = walkStart;
    if (walkStart) begin
      stateNext = ST_WALK;
    end else if (state == ST_WALK && entryValid) begin
      strobe.takeEntry = 1'b1;
      if (entryBad || entryLast) begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // an invalid entry from the datapath must close the walk (R3, R11)
  p_bad_entry_ends_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WALK && entryValid && entryBad && !walkStart) |=> state == ST_IDLE);

  // a start always opens a walk (R2)
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    walkStart |=> state == ST_WALK);

endmodule

// File: rtl/page_rights_datapath.sv
module page_rights_datapath
  import page_rights_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int RSVD_LO = 52,
  parameter int RSVD_HI = 62,
  parameter int XD_BIT  = 63,
  parameter int ERR_W   = 16,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [1:0]         accKind,
  input  logic               userMode,
  input  logic [1:0]         pageMode,
  input  logic               nxEnable,
  input  logic [ENTRY_W-1:0] entryData,
  output logic               entryBad,
  output logic               resultValid,
  output logic               faultValid,
  output logic [VEC_W-1:0]   faultVector,
  output logic [ERR_W-1:0]   faultCode
);

  function automatic logic [ENTRY_W-1:0] buildRsvdMask();
    logic [ENTRY_W-1:0] m;
    m = '0;
    for (int b = RSVD_LO; b <= RSVD_HI; b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [ENTRY_W-1:0] RSVD_MASK = buildRsvdMask();
  localparam logic [VEC_W-1:0]   VEC_PF    = VEC_W'(PF_VECTOR);

  accKind_e  kindQ;
  pageMode_e modeQ;
  logic      userQ, nxQ;
  logic      allW, allU, anyXd;

  logic xdActive, entPresent, rsvdHit, entXd;
  logic mergedW, mergedU, mergedXd, permit, deny;
  logic [ERR_W-1:0] codeNext;

  always_comb begin
    xdActive   = nxQ && (modeQ != PM_LEGACY);
    entPresent = entryData[PRESENT_BIT];
    rsvdHit    = (modeQ != PM_LEGACY) && |(entryData & RSVD_MASK);
    entXd      = xdActive && entryData[XD_BIT];
    entryBad   = !entPresent || rsvdHit;

    mergedW  = allW && entryData[WRITE_BIT];
    mergedU  = allU && entryData[USER_BIT];
    mergedXd = anyXd || entXd;

    unique case (kindQ)
      ACC_WRITE: permit = !userQ || (mergedU && mergedW);
      ACC_FETCH: permit = (!userQ || mergedU) && !mergedXd;
      default:   permit = !userQ || mergedU;
    endcase
    deny = entryBad || !permit;

    codeNext            = '0;
    codeNext[ERR_P]     = entPresent;
    codeNext[ERR_WR]    = (kindQ == ACC_WRITE);
    codeNext[ERR_US]    = userQ;
    codeNext[ERR_RSVD]  = entPresent && rsvdHit;
    codeNext[ERR_FETCH] = (kindQ == ACC_FETCH) && xdActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ       <= ACC_READ;
      modeQ       <= PM_LEGACY;
      userQ       <= 1'b0;
      nxQ         <= 1'b0;
      allW        <= 1'b1;
      allU        <= 1'b1;
      anyXd       <= 1'b0;
      resultValid <= 1'b0;
      faultValid  <= 1'b0;
      faultVector <= '0;
      faultCode   <= '0;
    end else begin
      if (strobe.clearAcc) begin
        kindQ <= accKind_e'(accKind);
        modeQ <= pageMode_e'(pageMode);
        userQ <= userMode;
        nxQ   <= nxEnable;
        allW  <= 1'b1;
        allU  <= 1'b1;
        anyXd <= 1'b0;
      end else if (strobe.takeEntry) begin
        allW  <= mergedW;
        allU  <= mergedU;
        anyXd <= mergedXd;
      end
      resultValid <= strobe.finish;
      faultValid  <= strobe.finish && deny;
      faultVector <= (strobe.finish && deny) ? VEC_PF : '0;
      faultCode   <= (strobe.finish && deny) ? codeNext : '0;
    end
  end

  p_fault_has_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> resultValid);

  p_result_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_vector_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> faultVector == VEC_PF);

  p_quiet_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (faultCode == '0 && faultVector == '0));

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    faultCode[ERR_W-1:ERR_USED] == '0);

  // supervisor data accesses only fault on invalid translations (R6)
  p_super_invalid_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !faultCode[ERR_US] && !faultCode[ERR_FETCH])
      |-> (!faultCode[ERR_P] || faultCode[ERR_RSVD]));

  p_nonpresent_no_rsvd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !faultCode[ERR_P]) |-> !faultCode[ERR_RSVD]);

  initial begin
    a_params_r4: assert (RSVD_LO <= RSVD_HI && RSVD_HI < ENTRY_W && XD_BIT < ENTRY_W
                         && ERR_W > ERR_USED && VEC_W >= 4);
  end

endmodule

// File: rtl/page_rights_check.sv
module page_rights_check
  import page_rights_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int RSVD_LO = 52,
  parameter int RSVD_HI = 62,
  parameter int XD_BIT  = 63,
  parameter int ERR_W   = 16,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               walkStart,
  input  logic [1:0]         accKind,
  input  logic               userMode,
  input  logic [1:0]         pageMode,
  input  logic               nxEnable,
  input  logic               entryValid,
  input  logic               entryLast,
  input  logic [ENTRY_W-1:0] entryData,
  output logic               resultValid,
  output logic               faultValid,
  output logic [VEC_W-1:0]   faultVector,
  output logic [ERR_W-1:0]   faultCode
);

  walkStrobe_t strobe;
  logic        entryBad;

  page_rights_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .walkStart  (walkStart),
    .entryValid (entryValid),
    .entryLast  (entryLast),
    .entryBad   (entryBad),
    .strobe     (strobe)
  );

  page_rights_datapath #(
    .ENTRY_W (ENTRY_W),
    .RSVD_LO (RSVD_LO),
    .RSVD_HI (RSVD_HI),
    .XD_BIT  (XD_BIT),
    .ERR_W   (ERR_W),
    .VEC_W   (VEC_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .accKind     (accKind),
    .userMode    (userMode),
    .pageMode    (pageMode),
    .nxEnable    (nxEnable),
    .entryData   (entryData),
    .entryBad    (entryBad),
    .resultValid (resultValid),
    .faultValid  (faultValid),
    .faultVector (faultVector),
    .faultCode   (faultCode)
  );

endmodule

// File: tb/page_rights_check_bench.sv
module page_rights_check_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkStart = 1'b0;
  logic [1:0]  accKind = 2'd0;
  logic        userMode = 1'b0;
  logic [1:0]  pageMode = 2'd0;
  logic        nxEnable = 1'b0;
  logic        entryValid = 1'b0;
  logic        entryLast = 1'b0;
  logic [63:0] entryData = '0;
  logic        resultValid, faultValid;
  logic [7:0]  faultVector;
  logic [15:0] faultCode;

  int checkCount = 0;
  int failCount  = 0;
  logic [63:0] ents [0:3];

  always #10 clk = ~clk;  // 50 MHz

  page_rights_check u_page_rights_check (
    .clk(clk), .rstN(rstN), .walkStart(walkStart), .accKind(accKind),
    .userMode(userMode), .pageMode(pageMode), .nxEnable(nxEnable),
    .entryValid(entryValid), .entryLast(entryLast), .entryData(entryData),
    .resultValid(resultValid), .faultValid(faultValid),
    .faultVector(faultVector), .faultCode(faultCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic p, input logic w, input logic u,
                                     input logic xd, input logic rsv);
    logic [63:0] e;
    e = '0;
    e[0] = p; e[1] = w; e[2] = u; e[63] = xd; e[55] = rsv;
    return e;
  endfunction

  task automatic fillAll(input logic [63:0] v);
    for (int i = 0; i < 4; i++) ents[i] = v;
  endtask

  // expIdx: index of the deciding entry, or -1 when no result is due
  task automatic runWalk(input string tag, input logic [1:0] kind, input logic usr,
                         input logic [1:0] mode, input logic nx, input int n,
                         input logic junk, input int expIdx, input logic expFault,
                         input int expCode);
    int seenIdx = -2;
    int pulses = 0;
    logic gotFault = 1'b0;
    int gotCode = 0;
    int gotVec = 0;
    @(negedge clk);
    walkStart = 1'b1; accKind = kind; userMode = usr; pageMode = mode; nxEnable = nx;
    entryValid = junk; entryLast = junk; entryData = mk(0, 0, 0, 0, 0);
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      if (resultValid) begin
        pulses++;
        if (seenIdx == -2) begin
          seenIdx = i - 1; gotFault = faultValid;
          gotCode = int'(faultCode); gotVec = int'(faultVector);
        end
      end
      walkStart = 1'b0;
      if (i < n) begin
        entryValid = 1'b1; entryData = ents[i]; entryLast = (i == n - 1);
      end else begin
        entryValid = 1'b0; entryLast = 1'b0; entryData = '0;
      end
    end
    if (expIdx < 0) begin
      check({tag, " result count"}, pulses, 0);
    end else begin
      check({tag, " result count"}, pulses, 1);
      check({tag, " result index"}, seenIdx, expIdx);
      check({tag, " fault"}, int'(gotFault), int'(expFault));
      check({tag, " code"}, gotCode, expCode);
      check({tag, " vector"}, gotVec, expFault ? 14 : 0);
    end
  endtask

  task automatic testReset();
    check("R1 resultValid", int'(resultValid), 0);
    check("R1 faultValid", int'(faultValid), 0);
    check("R1 vector", int'(faultVector), 0);
    check("R1 code", int'(faultCode), 0);
  endtask

  task automatic testSupervisor();
    fillAll(mk(1, 0, 0, 0, 0));
    runWalk("R6 sup write", 2'd1, 1'b0, 2'd2, 1'b1, 4, 1'b0, 3, 1'b0, 0);
    runWalk("R6 sup read", 2'd0, 1'b0, 2'd1, 1'b0, 3, 1'b0, 2, 1'b0, 0);
  endtask

  task automatic testUserRead();
    fillAll(mk(1, 0, 1, 0, 0));
    runWalk("R7 user read ok", 2'd0, 1'b1, 2'd2, 1'b0, 4, 1'b0, 3, 1'b0, 0);
    ents[2] = mk(1, 0, 0, 0, 0);
    runWalk("R7 user read denied", 2'd0, 1'b1, 2'd2, 1'b0, 4, 1'b0, 3, 1'b1, 5);
  endtask

  task automatic testUserWrite();
    fillAll(mk(1, 1, 1, 0, 0));
    runWalk("R8 user write ok", 2'd1, 1'b1, 2'd2, 1'b0, 4, 1'b0, 3, 1'b0, 0);
    ents[1] = mk(1, 0, 1, 0, 0);
    runWalk("R8 user write denied", 2'd1, 1'b1, 2'd2, 1'b0, 4, 1'b0, 3, 1'b1, 7);
  endtask

  task automatic testFetch();
    fillAll(mk(1, 0, 1, 0, 0));
    ents[3] = mk(1, 0, 1, 1, 0);
    runWalk("R9 user fetch xd", 2'd2, 1'b1, 2'd2, 1'b1, 4, 1'b0, 3, 1'b1, 21);
    runWalk("R9 fetch nx off", 2'd2, 1'b1, 2'd2, 1'b0, 4, 1'b0, 3, 1'b0, 0);
    runWalk("R9 sup fetch xd", 2'd2, 1'b0, 2'd2, 1'b1, 4, 1'b0, 3, 1'b1, 17);
    fillAll(mk(1, 0, 1, 1, 0));
    runWalk("R9 legacy ignores xd", 2'd2, 1'b1, 2'd0, 1'b1, 2, 1'b0, 1, 1'b0, 0);
    ents[0] = mk(1, 0, 0, 0, 0);
    runWalk("R10 legacy fetch no bit4", 2'd2, 1'b1, 2'd0, 1'b1, 2, 1'b0, 1, 1'b1, 5);
  endtask

  task automatic testNotPresent();
    fillAll(mk(1, 1, 1, 0, 0));
    ents[1] = mk(0, 1, 1, 0, 0);
    runWalk("R3 R11 early stop", 2'd1, 1'b0, 2'd2, 1'b1, 4, 1'b0, 1, 1'b1, 2);
    fillAll(mk(1, 1, 1, 0, 0));
    ents[0] = mk(0, 0, 0, 0, 0);
    runWalk("R3 R10 fetch root absent", 2'd2, 1'b1, 2'd2, 1'b1, 4, 1'b0, 0, 1'b1, 20);
  endtask

  task automatic testReserved();
    fillAll(mk(1, 1, 1, 0, 0));
    ents[1] = mk(1, 1, 1, 0, 1);
    runWalk("R4 rsvd pae", 2'd0, 1'b1, 2'd1, 1'b0, 3, 1'b0, 1, 1'b1, 13);
    runWalk("R4 rsvd legacy ignored", 2'd0, 1'b1, 2'd0, 1'b0, 2, 1'b0, 1, 1'b0, 0);
    ents[0] = mk(0, 1, 1, 0, 1);
    runWalk("R4 absent beats rsvd", 2'd0, 1'b1, 2'd1, 1'b0, 3, 1'b0, 0, 1'b1, 4);
  endtask

  task automatic testStartAndIdle();
    int pulses = 0;
    fillAll(mk(1, 1, 1, 0, 0));
    runWalk("R2 start-cycle entry ignored", 2'd0, 1'b0, 2'd2, 1'b0, 4, 1'b1, 3, 1'b0, 0);
    fillAll(mk(1, 0, 0, 0, 0));
    runWalk("R2 prior walk denied", 2'd0, 1'b1, 2'd1, 1'b0, 3, 1'b0, 2, 1'b1, 5);
    fillAll(mk(1, 1, 1, 0, 0));
    runWalk("R2 start clears rights", 2'd0, 1'b1, 2'd1, 1'b0, 3, 1'b0, 2, 1'b0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (resultValid) pulses++;
      entryValid = (i < 3); entryLast = (i < 3); entryData = mk(0, 0, 0, 0, 0);
    end
    check("R2 R11 idle entries ignored", pulses, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSupervisor();
    testUserRead();
    testUserWrite();
    testFetch();
    testNotPresent();
    testReserved();
    testStartAndIdle();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule